// File: doc/BRIEF.md
# Sign-Magnitude Decimal Sum Checker

This block watches a sign-magnitude packed-BCD adder/subtractor and flags a wrong magnitude result while the adder runs. It gets the two operand signs, the two operand magnitudes, the add/subtract control and the magnitude the adder produced. From these it works out which of three results the adder should have formed: the magnitude sum, X minus Y, or Y minus X. It then checks the adder's digits against that result. It never forms the difference itself.

The check runs in hexadecimal carry-save form. A decimal carry-prefix chain over X and the pre-biased Y gives the decimal digit carries and the magnitude order of X and Y. Those carries steer a +6 correction onto each Y digit. The result digits are either bit-inverted or, on the Y minus X path, offset by six, which turns them into the inverse of their nines' complement. One 3:2 compression followed by an all-ones test of sum and shifted carry then decides the error flag. The block also registers the sign the result should carry, which a surrounding pipeline or a test model can use. That sign is not checked.

Top module: `bcd_sm_sum_checker`

## Requirements
- R1: While `rst_n` is low, `err` and `res_sign` are 0.
- R2: The effective operation is `sign_x ^ sign_y ^ op_sub`. A value of 0 selects the magnitude sum and a value of 1 selects the magnitude difference.
- R3: Digit i of each magnitude sits in bits [4i+3:4i], with the least significant digit at bit 0. With effective add, `err` is 0 exactly when `mag_s` equals (X + Y) mod 10^DIGITS.
- R4: With effective subtract and X ≥ Y, `err` is 0 exactly when `mag_s` equals X − Y.
- R5: With effective subtract and X < Y, `err` is 0 exactly when `mag_s` equals Y − X. A zero `mag_s` on this path always raises `err`.
- R6: With effective subtract and X = Y, a zero `mag_s` is accepted and every other value raises `err`.
- R7: Any `mag_s` that differs from the expected magnitude raises `err`. This includes single-bit faults and non-decimal digit codes 10 to 15.
- R8: `res_sign` equals `sign_x`, except on effective subtract with X < Y, where it equals the inverse of `sign_x`.
- R9: Both outputs are registered. They show the verdict on the inputs sampled at the previous rising clock edge and are unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sign_x | input | 1 | Sign of operand X (1 = negative) |
| sign_y | input | 1 | Sign of operand Y (1 = negative) |
| op_sub | input | 1 | 1 requests X − Y, 0 requests X + Y |
| mag_x | input | 4*DIGITS | Packed-BCD magnitude of X |
| mag_y | input | 4*DIGITS | Packed-BCD magnitude of Y |
| mag_s | input | 4*DIGITS | Packed-BCD magnitude produced by the checked adder |
| err | output | 1 | 1 when `mag_s` is not the correct magnitude |
| res_sign | output | 1 | Sign the correct result carries |

## Verification
Both `err` and `res_sign` are due one rising edge after the inputs they judge. The bench drives each vector on a falling edge and reads the outputs on the following falling edge, half a period after the capturing edge. A latency check also reads the outputs just after a new drive, before any edge, and expects the old verdict to hold. The reset check drives a mismatching vector while reset is held and expects both outputs to stay low on the falling edge that follows.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef struct packed {
        logic err;
        logic rsign;
    } chk_state_t;

    function automatic logic [3:0] nines_digit(input logic [3:0] d);
        return 4'd9 - d;
    endfunction

endpackage

// File: rtl/smc_carry_chain.sv
module smc_carry_chain #(
    parameter int DIGITS = 16,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    output logic [DIGITS-1:0] grp_gen,
    output logic [DIGITS-1:0] grp_all9
);

    logic [DIGITS-1:0] dgen;
    logic [DIGITS-1:0] dprop;

    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        logic [4:0] dsum;
        assign dsum     = {1'b0, opa[4*i +: 4]} + {1'b0, opb[4*i +: 4]};
        assign dgen[i]  = (dsum >= 5'd10);
        assign dprop[i] = (dsum >= 5'd9);

        if (i == 0) begin : g_lsd
            assign grp_gen[i]  = dgen[i];
            assign grp_all9[i] = dprop[i];
        end else begin : g_up
            assign grp_gen[i]  = dgen[i] | (dprop[i] & grp_gen[i-1]);
            assign grp_all9[i] = dprop[i] & grp_all9[i-1];
        end
    end

endmodule

// File: rtl/smc_csa_allones.sv
module smc_csa_allones #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] in_c,
    input  logic             cin,
    output logic             all_ones
);

    logic [WIDTH-1:0] sv;
    logic [WIDTH-1:0] cv;
    logic [WIDTH-1:0] cv_sh;

    assign sv       = in_a ^ in_b ^ in_c;
    assign cv       = (in_a & in_b) | (in_a & in_c) | (in_b & in_c);
    assign cv_sh    = {cv[WIDTH-2:0], cin};
    assign all_ones = &(sv ^ cv_sh);

endmodule

// File: rtl/bcd_sm_sum_checker.sv
module bcd_sm_sum_checker #(
    parameter int DIGITS = 16,
    localparam int W = 4 * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sign_x,
    input  logic         sign_y,
    input  logic         op_sub,
    input  logic [W-1:0] mag_x,
    input  logic [W-1:0] mag_y,
    input  logic [W-1:0] mag_s,
    output logic         err,
    output logic         res_sign
);

    import smc_pkg::*;

    logic              eff_sub;
    logic [W-1:0]      y_pre;
    logic [DIGITS-1:0] grp_gen;
    logic [DIGITS-1:0] grp_all9;
    logic              x_ge_y;
    logic              swap_path;
    logic              carry0;
    logic [DIGITS:0]   dcarry;
    logic [W-1:0]      y_corr;
    logic [W-1:0]      s_term;
    logic              sum_ok;

    chk_state_t state_d;
    chk_state_t state_q;

    // effective operation: 1 means the magnitudes are subtracted
    assign eff_sub = sign_x ^ sign_y ^ op_sub;

    // Y becomes its nines' complement on effective subtract
    for (genvar i = 0; i < DIGITS; i++) begin : g_ypre
        assign y_pre[4*i +: 4] = eff_sub ? nines_digit(mag_y[4*i +: 4])
                                         : mag_y[4*i +: 4];
    end

    smc_carry_chain #(.DIGITS(DIGITS)) u_chain (
        .opa      (mag_x),
        .opb      (y_pre),
        .grp_gen  (grp_gen),
        .grp_all9 (grp_all9)
    );

    // X >= Y exactly when X + nines(Y) + 1 carries out of the top digit
    assign x_ge_y    = grp_gen[DIGITS-1] | grp_all9[DIGITS-1];
    assign swap_path = eff_sub & ~x_ge_y;
    assign carry0    = eff_sub & x_ge_y;

    assign dcarry[0] = carry0;
    for (genvar i = 0; i < DIGITS; i++) begin : g_corr
        assign dcarry[i+1] = grp_gen[i] | (grp_all9[i] & carry0);
        // a decimal carry out of digit i needs +6 to become a hex carry
        assign y_corr[4*i +: 4] = y_pre[4*i +: 4] + (dcarry[i+1] ? 4'd6 : 4'd0);
        // swap path compares against nines(S); its inverse is S + 6
        assign s_term[4*i +: 4] = swap_path ? (mag_s[4*i +: 4] + 4'd6)
                                            : ~mag_s[4*i +: 4];
    end

    smc_csa_allones #(.WIDTH(W)) u_csa (
        .in_a     (mag_x),
        .in_b     (y_corr),
        .in_c     (s_term),
        .cin      (carry0),
        .all_ones (sum_ok)
    );

    always_comb begin
        state_d       = state_q;
        state_d.err   = ~sum_ok;
        state_d.rsign = sign_x ^ swap_path;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign err      = state_q.err;
    assign res_sign = state_q.rsign;

endmodule

// File: rtl/bcd_sm_sum_checker_sva.sv
module bcd_sm_sum_checker_sva #(
    parameter int DIGITS = 16,
    localparam int W = 4 * DIGITS
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sign_x,
    input logic         sign_y,
    input logic         op_sub,
    input logic [W-1:0] mag_x,
    input logic [W-1:0] mag_y,
    input logic [W-1:0] mag_s,
    input logic         err,
    input logic         res_sign
);

    logic esub;
    assign esub = sign_x ^ sign_y ^ op_sub;

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!err && !res_sign));

    a_r3_add_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (!esub && mag_y == '0 && mag_s == mag_x) |=> !err);

    a_r5_swap_zero_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (esub && mag_x < mag_y && mag_s == '0) |=> err);

    a_r6_equal_zero_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (esub && mag_x == mag_y && mag_s == '0) |=> !err);

    a_r8_sign_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!esub || mag_x >= mag_y) |=> (res_sign == $past(sign_x)));

    a_r8_sign_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (esub && mag_x < mag_y) |=> (res_sign != $past(sign_x)));

endmodule

bind bcd_sm_sum_checker bcd_sm_sum_checker_sva #(.DIGITS(DIGITS)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .sign_x   (sign_x),
    .sign_y   (sign_y),
    .op_sub   (op_sub),
    .mag_x    (mag_x),
    .mag_y    (mag_y),
    .mag_s    (mag_s),
    .err      (err),
    .res_sign (res_sign)
);

// File: tb/test_bcd_sm_sum_checker.sv
`timescale 1ns/1ps
module test_bcd_sm_sum_checker;

    localparam int P = 4;
    localparam int W = 4 * P;
    localparam int MODV = 10000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sign_x = 1'b0;
    logic         sign_y = 1'b0;
    logic         op_sub = 1'b0;
    logic [W-1:0] mag_x = '0;
    logic [W-1:0] mag_y = '0;
    logic [W-1:0] mag_s = '0;
    logic         err;
    logic         res_sign;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_sm_sum_checker #(.DIGITS(P)) i_bcd_sm_sum_checker (
        .clk(clk), .rst_n(rst_n), .sign_x(sign_x), .sign_y(sign_y),
        .op_sub(op_sub), .mag_x(mag_x), .mag_y(mag_y), .mag_s(mag_s),
        .err(err), .res_sign(res_sign)
    );

    // {sx, sy, sub, X, Y, S, exp_err, exp_sign}
    localparam logic [52:0] VEC [0:11] = '{
        {3'b000, 16'h1234, 16'h4321, 16'h5555, 1'b0, 1'b0}, // R3
        {3'b000, 16'h0999, 16'h0001, 16'h1000, 1'b0, 1'b0}, // R3 ripple
        {3'b000, 16'h9999, 16'h0001, 16'h0000, 1'b0, 1'b0}, // R3 wrap
        {3'b001, 16'h5000, 16'h1234, 16'h3766, 1'b0, 1'b0}, // R4
        {3'b001, 16'h1234, 16'h5000, 16'h3766, 1'b0, 1'b1}, // R5
        {3'b010, 16'h0100, 16'h0001, 16'h0099, 1'b0, 1'b0}, // R2 R4
        {3'b100, 16'h0001, 16'h0100, 16'h0099, 1'b0, 1'b0}, // R2 R5
        {3'b111, 16'h4444, 16'h4444, 16'h0000, 1'b0, 1'b1}, // R6
        {3'b011, 16'h4444, 16'h4444, 16'h8888, 1'b0, 1'b0}, // R2 add
        {3'b111, 16'h4444, 16'h4444, 16'h8888, 1'b1, 1'b1}, // R6 reject
        {3'b000, 16'h1234, 16'h4321, 16'h555A, 1'b1, 1'b0}, // R7 bad code
        {3'b001, 16'h1234, 16'h5000, 16'h3767, 1'b1, 1'b1}  // R7
    };

    function automatic int to_int(input logic [W-1:0] b);
        int v = 0;
        for (int i = P - 1; i >= 0; i--) v = v * 10 + int'(b[4*i +: 4]);
        return v;
    endfunction

    function automatic logic [W-1:0] to_bcd(input int v);
        logic [W-1:0] b = '0;
        int t = v;
        for (int i = 0; i < P; i++) begin
            b[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return b;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic sx, input logic sy, input logic sb,
                         input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic [W-1:0] s);
        sign_x = sx; sign_y = sy; op_sub = sb;
        mag_x = x; mag_y = y; mag_s = s;
    endtask

    // model: expected magnitude and sign from the requirements
    task automatic model(input logic sx, input logic sy, input logic sb,
                         input int xv, input int yv,
                         output int m, output logic sg);
        logic e = sx ^ sy ^ sb;
        if (!e) begin
            m = (xv + yv) % MODV; sg = sx;
        end else if (xv >= yv) begin
            m = xv - yv; sg = sx;
        end else begin
            m = yv - xv; sg = ~sx;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset err", int'(err), 0);
        check("R1 reset sign", int'(res_sign), 0);
        // mismatching vector while reset is held
        drive(1'b1, 1'b0, 1'b0, 16'h0010, 16'h0500, 16'h0001);
        @(negedge clk);
        check("R1 err held low", int'(err), 0);
        check("R1 sign held low", int'(res_sign), 0);
        rst_n = 1'b1;

        // table walk
        foreach (VEC[k]) begin
            logic [52:0] v = VEC[k];
            drive(v[52], v[51], v[50], v[49:34], v[33:18], v[17:2]);
            @(negedge clk);
            check($sformatf("R3-R7 table %0d err", k), int'(err), int'(v[1]));
            check($sformatf("R8 table %0d sign", k), int'(res_sign), int'(v[0]));
        end

        // sweep all sign/sub combinations, correct and faulted sums
        for (int c = 0; c < 8; c++) begin
            for (int j = 0; j < 10; j++) begin
                int xv = (j * 3791 + 17 + c * 11) % MODV;
                int yv = (j == 9) ? xv : (j * 5923 + 401 + c * 7) % MODV;
                int m;
                logic sg;
                logic [W-1:0] good;
                logic [W-1:0] bad;
                model(c[2], c[1], c[0], xv, yv, m, sg);
                good = to_bcd(m);
                drive(c[2], c[1], c[0], to_bcd(xv), to_bcd(yv), good);
                @(negedge clk);
                check("R2 R3 R4 R5 R6 sweep good sum", int'(err), 0);
                check("R8 sweep sign", int'(res_sign), int'(sg));
                bad = good ^ (16'h1 << ((c * 5 + j * 3) % W));
                mag_s = bad;
                @(negedge clk);
                check("R7 sweep faulted sum", int'(err), 1);
            end
        end

        // R5: zero sum on the swap path
        drive(1'b0, 1'b0, 1'b1, 16'h0000, 16'h0001, 16'h0000);
        @(negedge clk);
        check("R5 zero on swap path", int'(err), 1);
        // R6: equal magnitudes, off-by-one sum
        drive(1'b1, 1'b0, 1'b0, 16'h9999, 16'h9999, 16'h0001);
        @(negedge clk);
        check("R6 equal nonzero", int'(err), 1);

        // R9: verdict changes only at the next rising edge
        drive(1'b0, 1'b0, 1'b0, 16'h0001, 16'h0001, 16'h0002);
        @(negedge clk);
        check("R9 good verdict", int'(err), 0);
        mag_s = 16'h0003;
        #1;
        check("R9 old verdict holds", int'(err), 0);
        @(negedge clk);
        check("R9 new verdict", int'(err), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule